// File: doc/BRIEF.md
# Equal-Weight PWM Subframe Scheduler

This block sequences the pixel data of a display that is driven purely on or off, with brightness set by how many equal-length time slices a pixel spends lit. A gray depth of n bits gives 2^n − 1 subframes per frame. Each subframe starts with a programming phase and ends with an emission phase. In the programming phase the rows are visited in ascending order, one row per slot. In the emission phase the programmed image is held on the panel.

In every programming slot the block first issues a read of one row of gray values from an external synchronous memory. One cycle later it raises a row strobe and presents one bit per column: the bit is 1 when that pixel's gray value is greater than the current subframe index. Over a frame, a pixel of gray value g is therefore lit in exactly g subframes. A start-of-frame pulse starts a frame, or restarts one that is running. When the last subframe's emission ends, the block goes idle.

The programming slot is at least two cycles long, so that each strobe stays inside its own slot. The emission phase is never shorter than the time needed to program the remaining rows. Both lengths are raised to these floors when the parameters ask for less.

Top module: `pwm_sf_sched`

## Requirements
- R1: While reset is held, and after it is released until the first start pulse, the block is idle: `rd_en`, `row_stb`, `prog_ph` and `emit_ph` are 0, and `sf_idx` and `col_bits` are 0.
- R2: One cycle after `sof` is sampled high, `prog_ph` is 1, `sf_idx` is 0, `rd_en` is 1 and `rd_addr` is 0.
- R3: Each programming slot lasts PS cycles, where PS is the larger of PROG_CYC and 2. `rd_en` is high only in the first cycle of a slot, and `rd_addr` then holds the slot's row. Rows are visited from 0 to ROWS−1.
- R4: `row_stb` is high exactly one cycle after each read request that is not cancelled by `sof`. While it is high, `row_addr` equals the address of that request.
- R5: While `row_stb` is high, `col_bits[c]` is 1 exactly when the gray value in `rd_data[c*GRAY_W +: GRAY_W]` is greater than `sf_idx`. At all other times `col_bits` is 0.
- R6: Over a whole frame, a pixel of gray 0 is never lit and a pixel of gray 2^GRAY_W−1 is lit in every subframe.
- R7: After the last row's slot, the emission phase lasts EL cycles, where EL is the larger of EMIT_CYC and (ROWS−1)·PS, with a minimum of 1. No read is issued during emission.
- R8: `sf_idx` stays constant within a subframe and rises by one after each emission phase. After the emission of subframe 2^GRAY_W−2 the block returns to idle with `sf_idx` at 0.
- R9: A `sof` pulse in any state restarts the frame as in R2, and it cancels the strobe of a read issued in the same cycle.
- R10: `prog_ph` and `emit_ph` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame pulse |
| rd_en | output | 1 | Row read request to pixel memory |
| rd_addr | output | RW | Row address of the read request |
| rd_data | input | COLS*GRAY_W | Gray values of the requested row, one cycle after the request |
| row_stb | output | 1 | Row programming strobe |
| row_addr | output | RW | Row being programmed while the strobe is high |
| col_bits | output | COLS | On/off bit for each column of the strobed row |
| sf_idx | output | GRAY_W | Current subframe index |
| prog_ph | output | 1 | Programming phase indicator |
| emit_ph | output | 1 | Emission phase indicator |

## Verification
The assertions assume that `sof` is a synchronous one-cycle pulse and that `rd_data` comes from a memory that returns a row one cycle after the request. They place no limit on the values `rd_data` carries. The bench drives `sof` for a single cycle each time, always on the falling edge. It answers each read from a one-cycle-latency model in which every row is the stimulus pattern rotated by the row number. This ties `col_bits` to the row address as well as to the subframe index. A second instance, built with parameters below both floors, runs under the same inputs.

// File: rtl/pwm_sf_sched.sv
module pwm_sf_sched #(
  parameter int ROWS     = 4,
  parameter int COLS     = 8,
  parameter int GRAY_W   = 3,
  parameter int PROG_CYC = 2,
  parameter int EMIT_CYC = 8,
  localparam int RW      = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sof,
  output logic                     rd_en,
  output logic [RW-1:0]            rd_addr,
  input  logic [COLS*GRAY_W-1:0]   rd_data,
  output logic                     row_stb,
  output logic [RW-1:0]            row_addr,
  output logic [COLS-1:0]          col_bits,
  output logic [GRAY_W-1:0]        sf_idx,
  output logic                     prog_ph,
  output logic                     emit_ph
);

  localparam int NSF   = (1 << GRAY_W) - 1;
  localparam int PS    = (PROG_CYC < 2) ? 2 : PROG_CYC;
  localparam int EMIN  = (ROWS - 1) * PS;
  localparam int EL0   = (EMIT_CYC < EMIN) ? EMIN : EMIT_CYC;
  localparam int EL    = (EL0 < 1) ? 1 : EL0;
  localparam int CMAX  = (PS > EL) ? PS : EL;
  localparam int CW    = $clog2(CMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_PROG, S_EMIT} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [RW-1:0]     row;
  logic [GRAY_W-1:0] sf;
  logic              stb_q;
  logic [RW-1:0]     stb_row;

  wire slot_end = (cnt == CW'(PS - 1));
  wire emit_end = (cnt == CW'(EL - 1));
  wire last_row = (row == RW'(ROWS - 1));
  wire last_sf  = (sf == GRAY_W'(NSF - 1));

  assign rd_en    = (st == S_PROG) && (cnt == '0);
  assign rd_addr  = row;
  assign row_stb  = stb_q;
  assign row_addr = stb_row;
  assign sf_idx   = sf;
  assign prog_ph  = (st == S_PROG);
  assign emit_ph  = (st == S_EMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      row <= '0;
      sf  <= '0;
    end else if (sof) begin
      st  <= S_PROG;
      cnt <= '0;
      row <= '0;
      sf  <= '0;
    end else begin
      case (st)
        S_PROG: begin
          if (slot_end) begin
            cnt <= '0;
            if (last_row) begin
              row <= '0;
              st  <= S_EMIT;
            end else begin
              row <= row + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_EMIT: begin
          if (emit_end) begin
            cnt <= '0;
            if (last_sf) begin
              sf <= '0;
              st <= S_IDLE;
            end else begin
              sf <= sf + 1'b1;
              st <= S_PROG;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          cnt <= '0;
          row <= '0;
          sf  <= '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q   <= 1'b0;
      stb_row <= '0;
    end else begin
      stb_q   <= rd_en && !sof;
      stb_row <= row;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_bits[c] = stb_q && (rd_data[c*GRAY_W +: GRAY_W] > sf);
  end

endmodule

// File: rtl/pwm_sf_sched_chk.sv
module pwm_sf_sched_chk #(
  parameter int RW     = 2,
  parameter int COLS   = 8,
  parameter int GRAY_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sof,
  input logic              rd_en,
  input logic [RW-1:0]     rd_addr,
  input logic              row_stb,
  input logic [RW-1:0]     row_addr,
  input logic [COLS-1:0]   col_bits,
  input logic [GRAY_W-1:0] sf_idx,
  input logic              prog_ph,
  input logic              emit_ph
);

  a_r2_sof_start: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (prog_ph && sf_idx == '0 && rd_en && rd_addr == '0));

  a_r4_stb_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !sof) |=> (row_stb && row_addr == $past(rd_addr)));

  a_r4_stb_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    row_stb |-> $past(rd_en));

  a_r5_bits_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !row_stb |-> (col_bits == '0));

  a_r7_no_read_in_emit: assert property (@(posedge clk) disable iff (!rst_n)
    emit_ph |-> !rd_en);

  a_r8_sf_hold_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_ph && $past(prog_ph) && !$past(sof)) |-> $stable(sf_idx));

  a_r9_sof_cancels_stb: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !row_stb);

  a_r10_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_ph && emit_ph));

endmodule

bind pwm_sf_sched pwm_sf_sched_chk #(.RW(RW), .COLS(COLS), .GRAY_W(GRAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sof(sof), .rd_en(rd_en), .rd_addr(rd_addr),
  .row_stb(row_stb), .row_addr(row_addr), .col_bits(col_bits), .sf_idx(sf_idx),
  .prog_ph(prog_ph), .emit_ph(emit_ph)
);

// File: tb/pwm_sf_sched_tb.sv
module pwm_sf_sched_tb;
  localparam int ROWS = 4;
  localparam int COLS = 8;
  localparam int GW   = 3;
  localparam int PCYC = 2;
  localparam int ECYC = 8;
  localparam int NSF  = 7;
  localparam int DW   = COLS * GW;
  localparam int NV   = 7;

  localparam logic [39:0] VEC [NV] = '{
    {24'h000000, 16'd0},
    {24'hFFFFFF, 16'd224},
    {24'hFAC688, 16'd112},
    {24'h053977, 16'd112},
    {24'hE38E38, 16'd112},
    {24'h249249, 16'd32},
    {24'hDB6DB6, 16'd192}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic sof = 0;
  logic [DW-1:0] img = '0;

  logic rd_en, row_stb, prog_ph, emit_ph;
  logic [1:0] rd_addr, row_addr;
  logic [DW-1:0] rd_data;
  logic [COLS-1:0] col_bits;
  logic [GW-1:0] sf_idx;

  logic c_rd_en, c_row_stb, c_prog_ph, c_emit_ph;
  logic [1:0] c_rd_addr, c_row_addr;
  logic [DW-1:0] c_rd_data;
  logic [COLS-1:0] c_col_bits;
  logic [GW-1:0] c_sf_idx;

  int nchk = 0;
  int nbad = 0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] row_data(input logic [DW-1:0] im, input int r);
    logic [2*DW-1:0] w;
    w = {im, im} << (r * GW);
    return w[2*DW-1:DW];
  endfunction

  always @(posedge clk) begin
    if (rd_en) rd_data <= row_data(img, int'(rd_addr));
    if (c_rd_en) c_rd_data <= row_data(img, int'(c_rd_addr));
  end

  pwm_sf_sched #(.ROWS(ROWS), .COLS(COLS), .GRAY_W(GW), .PROG_CYC(PCYC), .EMIT_CYC(ECYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .row_stb(row_stb), .row_addr(row_addr), .col_bits(col_bits),
    .sf_idx(sf_idx), .prog_ph(prog_ph), .emit_ph(emit_ph));

  pwm_sf_sched #(.ROWS(ROWS), .COLS(COLS), .GRAY_W(GW), .PROG_CYC(1), .EMIT_CYC(1)) u_dut_clamp (
    .clk(clk), .rst_n(rst_n), .sof(sof), .rd_en(c_rd_en), .rd_addr(c_rd_addr),
    .rd_data(c_rd_data), .row_stb(c_row_stb), .row_addr(c_row_addr), .col_bits(c_col_bits),
    .sf_idx(c_sf_idx), .prog_ph(c_prog_ph), .emit_ph(c_emit_ph));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic start_frame();
    sof = 1;
    @(negedge clk);
    sof = 0;
  endtask

  task automatic run_frame(input logic [DW-1:0] im, output int lit);
    lit = 0;
    for (int s = 0; s < NSF; s++) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < PCYC; c++) begin
          chk(prog_ph && !emit_ph && sf_idx == GW'(s), "R8",
              {29'd0, prog_ph, emit_ph, 1'b0} | 32'(sf_idx) << 4, 32'h4 | 32'(s) << 4);
          chk((rd_en == (c == 0)) && (c != 0 || rd_addr == 2'(r)), "R3",
              {30'd0, rd_en, 1'b0} | 32'(rd_addr) << 4, (c == 0) ? (32'h2 | 32'(r) << 4) : 32'(rd_addr) << 4);
          if (c == 1) begin
            logic [DW-1:0] rd;
            logic [COLS-1:0] exp;
            rd = row_data(im, r);
            for (int k = 0; k < COLS; k++) exp[k] = (rd[k*GW +: GW] > GW'(s));
            chk(row_stb && row_addr == 2'(r), "R4", {row_stb, 2'b0, row_addr}, {1'b1, 2'b0, 2'(r)});
            chk(col_bits == exp, "R5", 32'(col_bits), 32'(exp));
            lit += $countones(col_bits);
          end else begin
            chk(!row_stb && col_bits == '0, "R5", {row_stb, col_bits}, 32'd0);
          end
          @(negedge clk);
        end
      end
      for (int e = 0; e < ECYC; e++) begin
        chk(emit_ph && !prog_ph && !rd_en && !row_stb && sf_idx == GW'(s), "R7",
            {emit_ph, prog_ph, rd_en, row_stb, 1'b0, sf_idx}, {4'b1000, 1'b0, GW'(s)});
        @(negedge clk);
      end
    end
    chk(!prog_ph && !emit_ph && !rd_en && sf_idx == '0, "R8",
        {prog_ph, emit_ph, rd_en, 1'b0, sf_idx}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    int lit;
    int pc, ec, rc;
    repeat (3) @(negedge clk);
    chk(!rd_en && !row_stb && !prog_ph && !emit_ph && sf_idx == '0 && col_bits == '0, "R1",
        {rd_en, row_stb, prog_ph, emit_ph, 1'b0, sf_idx}, 32'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!rd_en && !row_stb && !prog_ph && !emit_ph && sf_idx == '0 && col_bits == '0, "R1",
        {rd_en, row_stb, prog_ph, emit_ph, 1'b0, sf_idx}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      img = VEC[v][39:16];
      start_frame();
      chk(prog_ph && sf_idx == '0 && rd_en && rd_addr == '0, "R2",
          {prog_ph, rd_en, rd_addr, 1'b0, sf_idx}, {2'b11, 2'b00, 1'b0, 3'b000});
      run_frame(img, lit);
      chk(lit == int'(VEC[v][15:0]), (VEC[v][15:0] == 16'd0 || VEC[v][15:0] == 16'd224) ? "R6" : "R5",
          32'(lit), 32'(VEC[v][15:0]));
      repeat (2) @(negedge clk);
    end

    img = 24'hFAC688;
    start_frame();
    repeat (2 * (ROWS * PCYC + ECYC) + PCYC) @(negedge clk);
    chk(rd_en && rd_addr == 2'd1 && sf_idx == 3'd2, "R3", {rd_en, rd_addr, 1'b0, sf_idx}, {1'b1, 2'd1, 1'b0, 3'd2});
    start_frame();
    chk(!row_stb && col_bits == '0, "R9", {row_stb, col_bits}, 32'd0);
    chk(prog_ph && sf_idx == '0 && rd_en && rd_addr == '0, "R9",
        {prog_ph, rd_en, rd_addr, 1'b0, sf_idx}, {2'b11, 2'b00, 1'b0, 3'b000});
    run_frame(img, lit);
    chk(lit == 112, "R9", 32'(lit), 32'd112);

    start_frame();
    pc = 0; ec = 0; rc = 0;
    while (c_prog_ph && pc < 100) begin
      if (c_rd_en) rc++;
      pc++;
      @(negedge clk);
    end
    while (c_emit_ph && ec < 100) begin
      ec++;
      @(negedge clk);
    end
    chk(pc == 8 && rc == 4, "R3", 32'(pc) << 8 | 32'(rc), 32'h0804);
    chk(ec == 6, "R7", 32'(ec), 32'd6);
    chk(c_prog_ph && c_sf_idx == 3'd1, "R8", {c_prog_ph, 1'b0, c_sf_idx}, {1'b1, 1'b0, 3'd1});

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule